// File: doc/BRIEF.md
# Full-Bridge PWM Generator with Fault Shutdown

This block drives the four switches of an H-bridge from a single PWM channel. A free-running period counter runs from zero up to a programmable limit, and the wrap point marks the period boundary. At each boundary the block latches a new pulse width and a new bridge direction. In forward drive one high-side leg is held on and the diagonal low-side leg is pulse-width modulated. In reverse drive the other diagonal pair is used in the same way.

A fault input, either an external trip pin or a comparator output chosen by a select input, passes through a synchronizer. While the synchronized fault is present, all four outputs are forced off, and a sticky shutdown status bit is set. Software clears the bit with a one-cycle clear pulse. When auto-restart is enabled, the bit clears by itself once the fault has gone. In both cases the outputs stay off until the next period boundary, so a resumed pulse is never cut short. A direction change is also held until the boundary, so the bridge never produces a runt pulse while it reverses.

Configuration values are plain input ports sampled by the block.

Top module: `fbpwm_top`

## Requirements
- R1: During and after reset all four outputs and `shut_sts` are 0. The outputs stay 0 until the first period boundary has passed.
- R2: `period_flag` is high for exactly one cycle in every `per_lim`+1 cycles. That cycle is the last cycle of a period.
- R3: With forward direction latched (`dir_rev`=0), `out_a` is 1 for the whole period, `out_d` carries the pulse, and `out_b` and `out_c` are 0.
- R4: With reverse direction latched (`dir_rev`=1), `out_c` is 1 for the whole period, `out_b` carries the pulse, and `out_a` and `out_d` are 0.
- R5: `duty` is latched at each period boundary. The modulated output is high for the first min(duty, `per_lim`+1) cycles of the period that follows. A latched duty of 0 keeps it low for the whole period.
- R6: A change of `dir_rev` in mid-period leaves the outputs unchanged until the next period boundary.
- R7: `trip_sel`=0 selects `fault_pin` as the fault source, and `trip_sel`=1 selects `cmp_trip`. The unselected source has no effect on the outputs or on `shut_sts`.
- R8: A fault (active high, level-sensitive) that is held on the selected source forces all four outputs to 0 and sets `shut_sts` by the third rising clock edge after it appears. This timing assumes two synchronizer stages.
- R9: `shut_sts` is sticky. It is cleared only by a `sw_clear` pulse, or by auto-restart, and only while the synchronized fault is absent. A clear while the fault is present has no effect.
- R10: With `auto_rst`=1, `shut_sts` clears by itself by the third clock edge after the selected fault source goes low.
- R11: After `shut_sts` clears, all outputs stay 0 up to and including the next cycle in which `period_flag` is high. Drive resumes in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| per_lim | input | W | Period counter limit; the period is per_lim+1 cycles |
| duty | input | W | Pulse width in cycles, latched at each boundary |
| dir_rev | input | 1 | 0 = forward drive, 1 = reverse drive |
| fault_pin | input | 1 | External trip input, active high |
| cmp_trip | input | 1 | Comparator trip input, active high |
| trip_sel | input | 1 | 0 = use fault_pin, 1 = use cmp_trip |
| auto_rst | input | 1 | Auto-restart enable |
| sw_clear | input | 1 | One-cycle pulse that clears the shutdown status |
| out_a | output | 1 | Forward steered leg |
| out_b | output | 1 | Reverse modulated leg |
| out_c | output | 1 | Reverse steered leg |
| out_d | output | 1 | Forward modulated leg |
| shut_sts | output | 1 | Sticky shutdown status |
| period_flag | output | 1 | High in the last cycle of each period |

## Verification
The hardest situation to reach is the window after the shutdown status has cleared but before the next boundary. In that window the bridge must stay dark even though no fault is present and drive is enabled. The bench reaches it both ways. It clears a held-off shutdown with a software pulse after the fault has dropped. It also lets auto-restart clear a comparator-sourced trip. In each case it then watches every cycle up to the boundary. Direction reversal is treated the same way: the bench flips `dir_rev` a few cycles into a period and confirms that the old diagonal keeps driving until the wrap.

// File: rtl/fbpwm_pkg.sv
package fbpwm_pkg;
  localparam int CW = 16;

  typedef enum logic {DIR_FWD = 1'b0, DIR_REV = 1'b1} dir_e;

  typedef struct packed {
    logic a;
    logic b;
    logic c;
    logic d;
  } bridge_t;

  // pulse level for a counter position against a latched width
  function automatic logic pwm_level(input logic [CW-1:0] pos, input logic [CW-1:0] width);
    return pos < width;
  endfunction

  // map direction, pulse and enable to the four switch levels
  function automatic bridge_t bridge_drive(input dir_e dir, input logic pulse, input logic en);
    bridge_t o;
    o = '0;
    if (en) begin
      if (dir == DIR_FWD) begin
        o.a = 1'b1;
        o.d = pulse;
      end else begin
        o.c = 1'b1;
        o.b = pulse;
      end
    end
    return o;
  endfunction
endpackage

// File: rtl/fbpwm_timebase.sv
module fbpwm_timebase #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] per_lim,
  input  logic [W-1:0] duty_in,
  input  logic         dir_in,
  output logic [W-1:0] cnt,
  output logic [W-1:0] duty_sh,
  output fbpwm_pkg::dir_e dir_act,
  output logic         bnd,
  output logic         pulse
);
  import fbpwm_pkg::*;

  assign bnd   = (cnt == per_lim);
  assign pulse = pwm_level(CW'(cnt), CW'(duty_sh));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      duty_sh <= '0;
      dir_act <= DIR_FWD;
    end else if (bnd) begin
      cnt     <= '0;
      duty_sh <= duty_in;
      dir_act <= dir_e'(dir_in);
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fbpwm_trip.sv
module fbpwm_trip #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_pin,
  input  logic cmp_trip,
  input  logic trip_sel,
  input  logic auto_rst,
  input  logic sw_clear,
  output logic trip_s,
  output logic shut_sts
);
  logic            trip_raw;
  logic [SYNC-1:0] sr;

  assign trip_raw = trip_sel ? cmp_trip : fault_pin;
  assign trip_s   = sr[SYNC-1];

  generate
    if (SYNC == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= trip_raw;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[SYNC-2:0], trip_raw};
      end
    end
  endgenerate

  // a present fault wins over any clear request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   shut_sts <= 1'b0;
    else if (trip_s)              shut_sts <= 1'b1;
    else if (sw_clear || auto_rst) shut_sts <= 1'b0;
  end
endmodule

// File: rtl/fbpwm_gate.sv
module fbpwm_gate (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bnd,
  input  logic              trip_s,
  input  logic              shut_sts,
  input  fbpwm_pkg::dir_e   dir_act,
  input  logic              pulse,
  output logic              run,
  output fbpwm_pkg::bridge_t drive
);
  import fbpwm_pkg::*;

  // drive is re-armed only at a period wrap with the status already clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    run <= 1'b0;
    else if (trip_s)               run <= 1'b0;
    else if (bnd && !shut_sts)     run <= 1'b1;
  end

  assign drive = bridge_drive(dir_act, pulse, run);
endmodule

// File: rtl/fbpwm_top.sv
module fbpwm_top #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] per_lim,
  input  logic [W-1:0] duty,
  input  logic         dir_rev,
  input  logic         fault_pin,
  input  logic         cmp_trip,
  input  logic         trip_sel,
  input  logic         auto_rst,
  input  logic         sw_clear,
  output logic         out_a,
  output logic         out_b,
  output logic         out_c,
  output logic         out_d,
  output logic         shut_sts,
  output logic         period_flag
);
  import fbpwm_pkg::*;

  logic [W-1:0] cnt;
  logic [W-1:0] duty_sh;
  dir_e         dir_act;
  logic         bnd;
  logic         pulse;
  logic         trip_s;
  logic         run;
  bridge_t      drive;

  fbpwm_timebase #(.W(W)) u_tb (
    .clk(clk), .rst_n(rst_n), .per_lim(per_lim), .duty_in(duty), .dir_in(dir_rev),
    .cnt(cnt), .duty_sh(duty_sh), .dir_act(dir_act), .bnd(bnd), .pulse(pulse)
  );

  fbpwm_trip #(.SYNC(SYNC)) u_trip (
    .clk(clk), .rst_n(rst_n), .fault_pin(fault_pin), .cmp_trip(cmp_trip),
    .trip_sel(trip_sel), .auto_rst(auto_rst), .sw_clear(sw_clear),
    .trip_s(trip_s), .shut_sts(shut_sts)
  );

  fbpwm_gate u_gate (
    .clk(clk), .rst_n(rst_n), .bnd(bnd), .trip_s(trip_s), .shut_sts(shut_sts),
    .dir_act(dir_act), .pulse(pulse), .run(run), .drive(drive)
  );

  assign out_a       = drive.a;
  assign out_b       = drive.b;
  assign out_c       = drive.c;
  assign out_d       = drive.d;
  assign period_flag = bnd;
endmodule

// File: rtl/fbpwm_chk.sv
module fbpwm_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         out_a,
  input logic         out_b,
  input logic         out_c,
  input logic         out_d,
  input logic         shut_sts,
  input logic         period_flag,
  input logic         sw_clear,
  input logic         auto_rst,
  input logic         trip_s,
  input logic [W-1:0] cnt,
  input logic [W-1:0] duty_sh
);
  // R8: a synchronized fault blanks the bridge on the next edge
  p_blank_on_trip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trip_s |=> !(out_a || out_b || out_c || out_d) && shut_sts);

  // R9: status holds without a clear request
  p_status_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_sts && !sw_clear && !auto_rst) |=> shut_sts);

  // R10: auto-restart releases the status once the fault is gone
  p_auto_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_sts && auto_rst && !trip_s) |=> !shut_sts);

  // R11: drive only starts right after a period wrap
  p_resume_at_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_a || out_c) |-> $past(period_flag));

  // R6: a diagonal swap only happens across a wrap
  p_dir_at_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_a && $past(out_c)) || (out_c && $past(out_a))) |-> $past(period_flag));

  // R2: the counter restarts from zero after the flag
  p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    period_flag |=> (cnt == '0));

  // R5: a zero latched width never pulses
  p_zero_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_sh == '0) |-> !(out_b || out_d));

  // R3 R4: never both high-side legs, never a leg with its own pulse partner
  p_legs_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_a, out_c}) && !(out_a && out_b) && !(out_c && out_d));
endmodule

bind fbpwm_top fbpwm_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d),
  .shut_sts(shut_sts), .period_flag(period_flag), .sw_clear(sw_clear), .auto_rst(auto_rst),
  .trip_s(trip_s), .cnt(cnt), .duty_sh(duty_sh)
);

// File: tb/fbpwm_top_tb.sv
module fbpwm_top_tb;
  localparam int W   = 8;
  localparam int PER = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] per_lim = W'(PER);
  logic [W-1:0] duty = '0;
  logic dir_rev = 1'b0, fault_pin = 1'b0, cmp_trip = 1'b0, trip_sel = 1'b0;
  logic auto_rst = 1'b0, sw_clear = 1'b0;
  logic out_a, out_b, out_c, out_d, shut_sts, period_flag;

  int n_chk = 0;
  int n_bad = 0;
  int ca, cb, cc, cd;

  always #10 clk = ~clk;

  fbpwm_top #(.W(W), .SYNC(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .per_lim(per_lim), .duty(duty), .dir_rev(dir_rev),
    .fault_pin(fault_pin), .cmp_trip(cmp_trip), .trip_sel(trip_sel), .auto_rst(auto_rst),
    .sw_clear(sw_clear), .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d),
    .shut_sts(shut_sts), .period_flag(period_flag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int outs();
    return {out_a, out_b, out_c, out_d};
  endfunction

  task automatic to_wrap();
    int guard = 0;
    while (!period_flag && guard < 100) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic measure();
    to_wrap();
    ca = 0; cb = 0; cc = 0; cd = 0;
    repeat (PER + 1) begin
      @(negedge clk);
      ca += int'(out_a); cb += int'(out_b); cc += int'(out_c); cd += int'(out_d);
    end
  endtask

  task automatic t_reset();
    int bad = 0;
    check(outs() == 0 && !shut_sts, "R1 outputs in reset", outs(), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (outs() != 0 || shut_sts) bad++;
    end
    check(bad == 0, "R1 dark before first wrap", bad, 0);
  endtask

  task automatic t_period();
    int n = 0;
    to_wrap();
    do begin
      @(negedge clk);
      n++;
    end while (!period_flag && n < 100);
    check(n == PER + 1, "R2 flag spacing", n, PER + 1);
  endtask

  task automatic t_forward();
    duty = 8'd3; dir_rev = 1'b0;
    to_wrap(); @(negedge clk);
    measure();
    check(ca == PER + 1, "R3 out_a steady", ca, PER + 1);
    check(cb == 0 && cc == 0, "R3 reverse legs off", cb + cc, 0);
    check(cd == 3, "R5 forward width 3", cd, 3);
  endtask

  task automatic t_reverse();
    int bad = 0;
    duty = 8'd7;
    to_wrap();
    repeat (4) @(negedge clk);
    dir_rev = 1'b1;
    @(negedge clk);
    while (!period_flag) begin
      if (!(out_a && !out_c)) bad++;
      @(negedge clk);
    end
    if (!(out_a && !out_c)) bad++;
    check(bad == 0, "R6 held until wrap", bad, 0);
    measure();
    check(cc == PER + 1, "R4 out_c steady", cc, PER + 1);
    check(ca == 0 && cd == 0, "R4 forward legs off", ca + cd, 0);
    check(cb == 7, "R5 reverse width 7", cb, 7);
  endtask

  task automatic t_width_edges();
    duty = 8'd0;
    to_wrap(); @(negedge clk);
    measure();
    check(cb == 0, "R5 zero width", cb, 0);
    duty = 8'd15;
    to_wrap(); @(negedge clk);
    measure();
    check(cb == PER + 1, "R5 width above period", cb, PER + 1);
    duty = 8'd5;
  endtask

  task automatic t_sw_clear();
    int bad = 0;
    trip_sel = 1'b0; auto_rst = 1'b0;
    to_wrap(); repeat (2) @(negedge clk);
    fault_pin = 1'b1;
    repeat (3) @(negedge clk);
    check(outs() == 0, "R8 pin fault blanks", outs(), 0);
    check(shut_sts == 1'b1, "R8 status set", shut_sts, 1);
    sw_clear = 1'b1; @(negedge clk); sw_clear = 1'b0;
    @(negedge clk);
    check(shut_sts == 1'b1, "R9 clear ignored under fault", shut_sts, 1);
    fault_pin = 1'b0;
    repeat (20) @(negedge clk);
    check(shut_sts == 1'b1 && outs() == 0, "R9 sticky after fault", shut_sts, 1);
    to_wrap(); repeat (3) @(negedge clk);
    sw_clear = 1'b1; @(negedge clk); sw_clear = 1'b0;
    check(shut_sts == 1'b0, "R9 software clear", shut_sts, 0);
    while (!period_flag) begin
      if (outs() != 0) bad++;
      @(negedge clk);
    end
    if (outs() != 0) bad++;
    check(bad == 0, "R11 dark until wrap (sw)", bad, 0);
    @(negedge clk);
    check(out_c == 1'b1, "R11 resume after wrap (sw)", out_c, 1);
  endtask

  task automatic t_cmp_auto();
    int bad = 0;
    trip_sel = 1'b1; auto_rst = 1'b1;
    fault_pin = 1'b1;
    repeat (6) begin
      @(negedge clk);
      if (!out_c || shut_sts) bad++;
    end
    check(bad == 0, "R7 unselected pin ignored", bad, 0);
    fault_pin = 1'b0;
    to_wrap(); repeat (2) @(negedge clk);
    cmp_trip = 1'b1;
    repeat (3) @(negedge clk);
    check(outs() == 0 && shut_sts, "R7 comparator trips", outs(), 0);
    repeat (5) @(negedge clk);
    check(shut_sts == 1'b1, "R10 held while fault", shut_sts, 1);
    cmp_trip = 1'b0;
    repeat (3) @(negedge clk);
    check(shut_sts == 1'b0, "R10 auto clear", shut_sts, 0);
    bad = 0;
    while (!period_flag) begin
      if (outs() != 0) bad++;
      @(negedge clk);
    end
    if (outs() != 0) bad++;
    check(bad == 0, "R11 dark until wrap (auto)", bad, 0);
    @(negedge clk);
    check(out_c == 1'b1, "R11 resume after wrap (auto)", out_c, 1);
  endtask

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_period();
    t_forward();
    t_reverse();
    t_width_edges();
    t_sw_clear();
    t_cmp_auto();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule